// File: doc/BRIEF.md
# Dual-Channel Multi-Mode Timer/Counter

Two 8+8-bit count channels advance on a machine-cycle enable. Each channel runs either as a timer, advancing once per machine cycle, or as an event counter, advancing on falling edges of its own external pin. The pin is sampled only on machine-cycle enables, so a falling edge takes two samples to detect. The count changes on the enable after the one that saw the low sample, which limits the count rate to one event per two machine cycles.

A two-bit mode per channel selects the layout:
- **13-bit:** the low byte acts as a 5-bit prescaler into the high byte.
- **16-bit:** the two bytes form one 16-bit count.
- **8-bit auto-reload:** the low byte counts and reloads from the high byte.
- **Split:** channel 0 becomes two independent 8-bit counters, and its high byte takes over channel 1's run control and flag. Channel 1 holds still in the split code.

Each channel raises a sticky overflow flag. Software loads the bytes through a small write port and reads them on dedicated outputs.

Top module: `tmr_ctr_pair`

## Requirements
- R1: While rst_ni is low, every count byte and both flags read zero.
- R2: A channel with its counter-select low advances exactly once per clock in which both mce_i and its run bit are high. Clocks with mce_i low leave the count unchanged.
- R3: A channel with its counter-select high samples its pin only on mce_i clocks. A high sample followed by a low sample at the next enable produces one count, applied at the enable after that. A low level that appears and goes away between enables is not counted.
- R4: Mode code 1 forms a 16-bit count {hi,lo}. It wraps from 0xFFFF to 0x0000 and sets the channel flag.
- R5: Mode code 0 counts in lo bits 4:0 and carries into hi, while lo bits 7:5 keep their value. Rolling over from hi=0xFF with lo[4:0]=0x1F sets the flag.
- R6: Mode code 2 increments lo. When lo is 0xFF, the next increment loads lo from hi and sets the flag; hi is not changed.
- R7: Channel 0 in mode code 3 works as follows:
  - lo0 counts under run0, counter-select 0 and flag 0.
  - hi0 counts machine cycles under run1 and sets flag 1 on wrap.
  - Channel 1 overflows do not set flag 1.
- R8: Channel 1 in mode code 3 holds both of its bytes.
- R9: A flag stays set until its clear bit is pulsed. When set and clear arrive in the same clock, set wins.
- R10: A write with wr_addr_i 0/1/2/3 loads lo0/hi0/lo1/hi1 with wr_data_i. A write overrides a same-clock increment of that byte.
- R11: With its run bit low, a channel does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mce_i | input | 1 | Machine-cycle enable, one clock per machine cycle |
| mode0_i | input | 2 | Channel 0 mode code |
| mode1_i | input | 2 | Channel 1 mode code |
| ext_i | input | 2 | Per-channel counter select (1 = pin events) |
| run_i | input | 2 | Per-channel run control |
| pin_i | input | 2 | Per-channel external event pins |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 2 | Byte select: 0 lo0, 1 hi0, 2 lo1, 3 hi1 |
| wr_data_i | input | 8 | Write data |
| flag_clr_i | input | 2 | Per-flag clear |
| ch0_lo_o | output | 8 | Channel 0 low byte |
| ch0_hi_o | output | 8 | Channel 0 high byte |
| ch1_lo_o | output | 8 | Channel 1 low byte |
| ch1_hi_o | output | 8 | Channel 1 high byte |
| flag_o | output | 2 | Sticky overflow flags |

## Verification
The assertions assume that mce_i is a single-clock pulse and that the pin is steady around each sampling clock. They also assume the mode inputs change only while the affected counters are stopped or about to be rewritten. The bench meets these assumptions by giving each enable pulse its own clock with an idle clock after it, and by changing pins, modes and writes only on falling clock edges. Before each vector it stops the run bits, reloads the bytes and clears the flags.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_13    = 2'd0,
    TM_16    = 2'd1,
    TM_AR8   = 2'd2,
    TM_SPLIT = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_smp.sv
module tmr_edge_smp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mce_i,
  input  logic pin_i,
  output logic fall_o
);
  logic smp_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      fall_q <= 1'b0;
    end else if (mce_i) begin
      smp_q  <= pin_i;
      fall_q <= smp_q & ~pin_i;  // high sample then low sample
    end
  end

  assign fall_o = fall_q;

  a_r3_fall_det: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mce_i && smp_q && !pin_i) |=> fall_q);
  a_r3_no_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mce_i && !smp_q) |=> !fall_q);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mce_i |=> ($stable(smp_q) && $stable(fall_q)));
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
  import tmr_pkg::*;
#(
  parameter int  BYTE_W   = 8,
  parameter int  PRE_W    = 5,
  parameter bit  SPLIT_OK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              inc_i,
  input  logic              inc_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  localparam logic [BYTE_W-1:0]   BMAX  = '1;
  localparam logic [BYTE_W-1:0]   BONE  = BYTE_W'(1);
  localparam logic [PRE_W-1:0]    PMAX  = '1;
  localparam logic [PRE_W-1:0]    PONE  = PRE_W'(1);
  localparam logic [2*BYTE_W-1:0] WONE  = (2*BYTE_W)'(1);

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              ovf, ovf_hi;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    unique case (mode_i)
      TM_13: if (inc_i) begin
        if (lo_q[PRE_W-1:0] == PMAX) begin
          lo_d[PRE_W-1:0] = '0;
          hi_d            = hi_q + BONE;
          ovf             = (hi_q == BMAX);
        end else begin
          lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + PONE;
        end
      end
      TM_16: if (inc_i) begin
        {hi_d, lo_d} = {hi_q, lo_q} + WONE;
        ovf          = (hi_q == BMAX) && (lo_q == BMAX);
      end
      TM_AR8: if (inc_i) begin
        if (lo_q == BMAX) begin
          lo_d = hi_q;
          ovf  = 1'b1;
        end else begin
          lo_d = lo_q + BONE;
        end
      end
      TM_SPLIT: if (SPLIT_OK) begin
        if (inc_i) begin
          lo_d = lo_q + BONE;
          ovf  = (lo_q == BMAX);
        end
        if (inc_hi_i) begin
          hi_d   = hi_q + BONE;
          ovf_hi = (hi_q == BMAX);
        end
      end
      default: ;
    endcase
    if (wr_lo_i) lo_d = wr_data_i;
    if (wr_hi_i) hi_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign ovf_o    = ovf;
  assign ovf_hi_o = ovf_hi;

  a_r4_wrap16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_16 && inc_i && lo_q == BMAX && hi_q == BMAX && !wr_lo_i && !wr_hi_i)
    |=> (lo_q == '0 && hi_q == '0));
  a_r5_top_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_13 && !wr_lo_i) |=> (lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W])));
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_AR8 && inc_i && lo_q == BMAX && !wr_lo_i) |=> (lo_q == $past(hi_q)));
  a_r10_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (lo_q == $past(wr_data_i)));

  if (!SPLIT_OK) begin : g_no_split
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == TM_SPLIT && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));
  end
endmodule

// File: rtl/tmr_ctr_pair.sv
module tmr_ctr_pair
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mce_i,
  input  logic [1:0]        mode0_i,
  input  logic [1:0]        mode1_i,
  input  logic [1:0]        ext_i,
  input  logic [1:0]        run_i,
  input  logic [1:0]        pin_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [1:0]        flag_clr_i,
  output logic [BYTE_W-1:0] ch0_lo_o,
  output logic [BYTE_W-1:0] ch0_hi_o,
  output logic [BYTE_W-1:0] ch1_lo_o,
  output logic [BYTE_W-1:0] ch1_hi_o,
  output logic [1:0]        flag_o
);
  localparam int N_CH = 2;

  tmr_mode_e         mode_sel [N_CH];
  logic [N_CH-1:0]   fall, inc, inc_hi, ovf, ovf_hi, flag_set;
  logic [N_CH-1:0]   flag_q;
  logic [BYTE_W-1:0] lo [N_CH];
  logic [BYTE_W-1:0] hi [N_CH];
  logic              ch0_split;

  assign mode_sel[0] = tmr_mode_e'(mode0_i);
  assign mode_sel[1] = tmr_mode_e'(mode1_i);
  assign ch0_split   = (mode_sel[0] == TM_SPLIT);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tmr_edge_smp u_smp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mce_i (mce_i),
      .pin_i (pin_i[c]),
      .fall_o(fall[c])
    );

    assign inc[c] = mce_i & run_i[c] & (ext_i[c] ? fall[c] : 1'b1);

    // channel 0's high byte borrows channel 1's run bit in split mode
    if (c == 0) begin : g_hi_src
      assign inc_hi[c] = mce_i & run_i[1] & ch0_split;
    end else begin : g_hi_none
      assign inc_hi[c] = 1'b0;
    end

    tmr_cnt_core #(
      .BYTE_W  (BYTE_W),
      .PRE_W   (PRE_W),
      .SPLIT_OK(c == 0)
    ) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode_sel[c]),
      .inc_i    (inc[c]),
      .inc_hi_i (inc_hi[c]),
      .wr_lo_i  (wr_en_i && wr_addr_i == 2'(2*c)),
      .wr_hi_i  (wr_en_i && wr_addr_i == 2'(2*c+1)),
      .wr_data_i(wr_data_i),
      .lo_o     (lo[c]),
      .hi_o     (hi[c]),
      .ovf_o    (ovf[c]),
      .ovf_hi_o (ovf_hi[c])
    );
  end

  assign flag_set[0] = ovf[0];
  assign flag_set[1] = ch0_split ? ovf_hi[0] : (ovf[1] | ovf_hi[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (flag_set[i])        flag_q[i] <= 1'b1;
        else if (flag_clr_i[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  assign ch0_lo_o = lo[0];
  assign ch0_hi_o = hi[0];
  assign ch1_lo_o = lo[1];
  assign ch1_hi_o = hi[1];
  assign flag_o   = flag_q;

  a_r9_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && !flag_clr_i[0]) |=> flag_q[0]);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf[0] |=> flag_q[0]);
  a_r7_split_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch0_split && !ovf_hi[0] && !flag_q[1]) |=> !flag_q[1]);
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i[0] && !wr_en_i) |=> $stable(lo[0]));
endmodule

// File: tb/tmr_ctr_pair_tb.sv
module tmr_ctr_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mce = 1'b0;
  logic [1:0] mode0 = 2'd1, mode1 = 2'd1;
  logic [1:0] ext = '0, run = '0, pin = '0, clr = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] lo0, hi0, lo1, hi1;
  logic [1:0] flag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_ctr_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mce_i(mce), .mode0_i(mode0), .mode1_i(mode1),
    .ext_i(ext), .run_i(run), .pin_i(pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .flag_clr_i(clr), .ch0_lo_o(lo0), .ch0_hi_o(hi0),
    .ch1_lo_o(lo1), .ch1_hi_o(hi1), .flag_o(flag)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] ticks;
    logic [7:0] e_hi;
    logic [7:0] e_lo;
    logic       e_flag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'h00, 8'hFE, 8'd1, 8'h00, 8'hFF, 1'b0},
    '{2'd1, 8'h00, 8'hFF, 8'd1, 8'h01, 8'h00, 1'b0},
    '{2'd1, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},
    '{2'd1, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1},
    '{2'd0, 8'h00, 8'h1F, 8'd1, 8'h01, 8'h00, 1'b0},
    '{2'd0, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'hE0, 1'b1},
    '{2'd0, 8'h05, 8'hA3, 8'd2, 8'h05, 8'hA5, 1'b0},
    '{2'd2, 8'h80, 8'hFE, 8'd2, 8'h80, 8'h80, 1'b1},
    '{2'd2, 8'h10, 8'hFF, 8'd3, 8'h10, 8'h12, 1'b1},
    '{2'd2, 8'hF0, 8'h00, 8'd5, 8'hF0, 8'h05, 1'b0},
    '{2'd3, 8'h00, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1}
  };

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'd0:    return "R5";
      2'd1:    return "R4";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); mce = 1'b1;
    @(negedge clk); mce = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); clr = 2'b11;
    @(negedge clk); clr = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 lo0", lo0, 0); chk("R1 hi0", hi0, 0);
    chk("R1 lo1", lo1, 0); chk("R1 hi1", hi1, 0); chk("R1 flag", flag, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run = 2'b00;
      mode0 = VEC[i].mode;
      wr(2'd1, VEC[i].hi);
      wr(2'd0, VEC[i].lo);
      clr_flags();
      run = 2'b01;
      for (int t = 0; t < int'(VEC[i].ticks); t++) tick();
      run = 2'b00;
      @(negedge clk);
      chk(mode_tag(VEC[i].mode), hi0, VEC[i].e_hi);
      chk(mode_tag(VEC[i].mode), lo0, VEC[i].e_lo);
      chk(mode_tag(VEC[i].mode), flag[0], VEC[i].e_flag);
    end

    // R2: no count without mce, then one per enable
    mode0 = 2'd1; wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    run = 2'b01;
    repeat (10) @(negedge clk);
    chk("R2 no mce", lo0, 0);
    repeat (3) tick();
    chk("R2 three enables", lo0, 3);

    // R11: run low blocks counting
    run = 2'b00;
    repeat (4) tick();
    chk("R11 stopped", lo0, 3);

    // R3: counter function with sampled edges
    wr(2'd0, 8'h00);
    ext = 2'b01; run = 2'b01;
    pin[0] = 1'b1; tick();
    pin[0] = 1'b0; tick();
    chk("R3 latency", lo0, 0);
    tick();
    chk("R3 counted", lo0, 1);
    tick();
    chk("R3 single", lo0, 1);
    pin[0] = 1'b1; tick();
    @(negedge clk); pin[0] = 1'b0;
    @(negedge clk); pin[0] = 1'b1;
    tick(); tick();
    chk("R3 glitch", lo0, 1);
    ext = 2'b00; run = 2'b00;

    // R10: write beats same-clock increment
    wr(2'd0, 8'h10);
    run = 2'b01;
    @(negedge clk); mce = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h40;
    @(negedge clk); mce = 1'b0; wr_en = 1'b0;
    run = 2'b00;
    chk("R10 write wins", lo0, 8'h40);
    wr(2'd3, 8'h5A);
    chk("R10 hi1 addr", hi1, 8'h5A);

    // R9: set beats clear, flag sticks, clear works
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); clr_flags();
    run = 2'b01;
    @(negedge clk); mce = 1'b1; clr = 2'b01;
    @(negedge clk); mce = 1'b0; clr = 2'b00;
    run = 2'b00;
    chk("R9 set wins", flag[0], 1);
    repeat (5) @(negedge clk);
    chk("R9 sticky", flag[0], 1);
    @(negedge clk); clr = 2'b01;
    @(negedge clk); clr = 2'b00;
    chk("R9 cleared", flag[0], 0);

    // R7: split mode, hi0 runs on run1 and owns flag 1
    mode0 = 2'd3; mode1 = 2'd1;
    wr(2'd0, 8'h20); wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    clr_flags();
    run = 2'b10;
    tick();
    chk("R7 ch1 wrapped", {hi1, lo1}, 16'h0000);
    chk("R7 flag1 masked", flag[1], 0);
    chk("R7 hi0 counts", hi0, 1);
    chk("R7 lo0 idle", lo0, 8'h20);
    run = 2'b00;
    wr(2'd1, 8'hFF);
    run = 2'b10;
    tick();
    run = 2'b00;
    chk("R7 hi0 wrap", hi0, 0);
    chk("R7 flag1 set", flag[1], 1);

    // R8: channel 1 holds in mode code 3
    mode0 = 2'd1; mode1 = 2'd3;
    wr(2'd2, 8'h33); wr(2'd3, 8'h44); clr_flags();
    run = 2'b10;
    repeat (3) tick();
    run = 2'b00;
    chk("R8 lo1 held", lo1, 8'h33);
    chk("R8 hi1 held", hi1, 8'h44);
    chk("R8 no flag", flag[1], 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule